// File: doc/BRIEF.md
# Clear-on-Read Event Status and Interrupt Unit

This block collects event indications from the surrounding logic into a sticky status word of up to 32 bits and turns them into interrupt requests. A one-cycle pulse on an event input sets its status bit, and the bit stays set until the host reads the word. The read strobe returns the current status and wipes it at the next clock edge. Some bit positions, chosen by a parameter, also accept a level input. While that level is high the bit is set again on every cycle, so a persisting condition such as a search timeout cannot be cleared away by reads. It stays visible until the logic that drives the level is reset.

A mask register holds one enable per status bit. The mask only decides which bits may pull the interrupt lines low. The status bits are recorded whatever the mask holds. There are two active-low, registered interrupt outputs. The primary line is low whenever any status bit is set together with its mask bit. The secondary line carries the same request, but only while the configuration-mode input is high. Otherwise it stays high.

Top module: `cor_status_irq`

## Requirements
- R1: While reset is asserted and right after its release, the status word reads all zeros, the mask holds `MASK_RST` (default all zeros), and both interrupt outputs are high.
- R2: A 1 on bit i of `evt_pulse_i` at a clock edge makes bit i of `stat_o` read 1 after that edge.
- R3: `stat_o` shows the status in the cycle where `rd_stb_i` is high. After that edge, every bit without a new set condition in that same cycle reads 0.
- R4: When a set condition for bit i and `rd_stb_i` occur in the same cycle, bit i reads 1 after the edge.
- R5: Status bits are set the same way whether their mask bit is 0 or 1.
- R6: After every clock edge out of reset, `irq_pri_n_o` equals NOT of the OR over (status AND mask).
- R7: A write of `mask_wdata_i` with `mask_wr_i` high takes effect in the interrupt outputs right after the same clock edge.
- R8: After an edge where `cfg_mode_i` was high, `irq_sec_n_o` equals `irq_pri_n_o`. After an edge where `cfg_mode_i` was low, it is 1.
- R9: Bit i with `HOLD_BITS[i]` = 1 (default: bits 31..24) is set on every edge where `evt_hold_i[i]` is high, including edges with a read. On bits with `HOLD_BITS[i]` = 0, `evt_hold_i` has no effect.
- R10: Without a read, a set status bit stays 1 on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse_i | input | W | Event pulses, one per status bit |
| evt_hold_i | input | W | Level-held conditions; used only on HOLD_BITS positions |
| rd_stb_i | input | 1 | Host read strobe; clears the status at the edge |
| stat_o | output | W | Current status word |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | W | New mask value |
| cfg_mode_i | input | 1 | Enables the secondary interrupt output |
| irq_pri_n_o | output | 1 | Primary interrupt, active low |
| irq_sec_n_o | output | 1 | Secondary interrupt, active low, mode-gated |

## Verification
Every result is due exactly one clock edge after its stimulus. A pulse, a read, a mask write or a mode change shows up in `stat_o` and both interrupt lines right after the edge that samples it. The bench drives inputs just after a falling edge and compares all outputs one time unit after the next rising edge against a model stepped once per cycle. The one check made before an edge is the value returned during a read strobe, which is the status that existed before the clear.

// File: rtl/cor_pkg.sv
package cor_pkg;
    localparam logic IRQ_IDLE_N = 1'b1;

    typedef struct packed {
        logic pri_n;
        logic sec_n;
    } irq_pair_t;
endpackage

// File: rtl/cor_sticky_bank.sv
module cor_sticky_bank #(
    parameter int          W         = 32,
    parameter logic [W-1:0] HOLD_BITS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    input  logic [W-1:0] hold_i,
    input  logic         clear_i,
    output logic [W-1:0] stat_d_o,
    output logic [W-1:0] stat_q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] set_w;

    // per-bit set term; HOLD_BITS picks which bits also take the level input
    for (genvar i = 0; i < W; i++) begin : g_set
        assign set_w[i] = pulse_i[i] | (HOLD_BITS[i] & hold_i[i]);
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) st_d.bits = '0;
        // a set in the clearing cycle wins
        st_d.bits = st_d.bits | set_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_d_o = st_d.bits;
    assign stat_q_o = st_q.bits;
endmodule

// File: rtl/cor_mask_reg.sv
module cor_mask_reg #(
    parameter int          W        = 32,
    parameter logic [W-1:0] MASK_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_d_o,
    output logic [W-1:0] mask_q_o
);
    typedef struct packed {
        logic [W-1:0] en;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_i) m_d.en = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q.en <= MASK_RST;
        else        m_q    <= m_d;
    end

    assign mask_d_o = m_d.en;
    assign mask_q_o = m_q.en;
endmodule

// File: rtl/cor_irq_gen.sv
module cor_irq_gen #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_d_i,
    input  logic [W-1:0] mask_d_i,
    input  logic         mode_i,
    output logic         pri_n_o,
    output logic         sec_n_o
);
    import cor_pkg::*;

    irq_pair_t irq_d, irq_q;
    logic      req_w;

    // next-state values so status and mask changes reach the pins with the same edge
    assign req_w = |(stat_d_i & mask_d_i);

    always_comb begin
        irq_d.pri_n = ~req_w;
        irq_d.sec_n = mode_i ? ~req_w : IRQ_IDLE_N;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '{pri_n: IRQ_IDLE_N, sec_n: IRQ_IDLE_N};
        else        irq_q <= irq_d;
    end

    assign pri_n_o = irq_q.pri_n;
    assign sec_n_o = irq_q.sec_n;
endmodule

// File: rtl/cor_status_irq.sv
module cor_status_irq #(
    parameter int          W         = 32,
    parameter logic [W-1:0] HOLD_BITS = 32'hFF00_0000,
    parameter logic [W-1:0] MASK_RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_pulse_i,
    input  logic [W-1:0] evt_hold_i,
    input  logic         rd_stb_i,
    output logic [W-1:0] stat_o,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic         cfg_mode_i,
    output logic         irq_pri_n_o,
    output logic         irq_sec_n_o
);
    logic [W-1:0] stat_d, stat_q, mask_d, mask_q;

    cor_sticky_bank #(.W(W), .HOLD_BITS(HOLD_BITS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (evt_pulse_i),
        .hold_i   (evt_hold_i),
        .clear_i  (rd_stb_i),
        .stat_d_o (stat_d),
        .stat_q_o (stat_q)
    );

    cor_mask_reg #(.W(W), .MASK_RST(MASK_RST)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (mask_wr_i),
        .wdata_i  (mask_wdata_i),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q)
    );

    cor_irq_gen #(.W(W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_d_i (stat_d),
        .mask_d_i (mask_d),
        .mode_i   (cfg_mode_i),
        .pri_n_o  (irq_pri_n_o),
        .sec_n_o  (irq_sec_n_o)
    );

    assign stat_o = stat_q;
endmodule

// File: rtl/cor_status_irq_chk.sv
module cor_status_irq_chk #(
    parameter int          W         = 32,
    parameter logic [W-1:0] HOLD_BITS = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_pulse_i,
    input logic [W-1:0] evt_hold_i,
    input logic         rd_stb_i,
    input logic [W-1:0] stat_o,
    input logic         cfg_mode_i,
    input logic         irq_pri_n_o,
    input logic         irq_sec_n_o,
    input logic [W-1:0] mask_q
);
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse_i != '0) |=> ((stat_o & $past(evt_pulse_i)) == $past(evt_pulse_i)));

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && (evt_pulse_i == '0) && ((evt_hold_i & HOLD_BITS) == '0)) |=> (stat_o == '0));

    a_r9_hold_resets: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_hold_i & HOLD_BITS) != '0) |=>
            ((stat_o & $past(evt_hold_i & HOLD_BITS)) == $past(evt_hold_i & HOLD_BITS)));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    a_r6_primary_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pri_n_o == ~|(stat_o & mask_q));

    a_r8_secondary_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode_i |=> irq_sec_n_o);

    a_r8_secondary_on: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode_i |=> (irq_sec_n_o == irq_pri_n_o));
endmodule

bind cor_status_irq cor_status_irq_chk #(.W(W), .HOLD_BITS(HOLD_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse_i (evt_pulse_i),
    .evt_hold_i  (evt_hold_i),
    .rd_stb_i    (rd_stb_i),
    .stat_o      (stat_o),
    .cfg_mode_i  (cfg_mode_i),
    .irq_pri_n_o (irq_pri_n_o),
    .irq_sec_n_o (irq_sec_n_o),
    .mask_q      (mask_q)
);

// File: tb/sim_cor_status_irq.sv
`timescale 1ns/1ps
module sim_cor_status_irq;
    localparam int          W    = 32;
    localparam logic [31:0] HOLD = 32'hFF00_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pulse = '0, hold = '0, mdata = '0;
    logic         rd = 1'b0, mwr = 1'b0, mode = 1'b0;
    logic [W-1:0] stat;
    logic         pri_n, sec_n;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [W-1:0] m_stat = '0, m_mask = '0;
    logic         m_pri = 1'b1, m_sec = 1'b1;

    always #4 clk = ~clk;

    cor_status_irq u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse_i(pulse), .evt_hold_i(hold),
        .rd_stb_i(rd), .stat_o(stat), .mask_wr_i(mwr), .mask_wdata_i(mdata),
        .cfg_mode_i(mode), .irq_pri_n_o(pri_n), .irq_sec_n_o(sec_n)
    );

    function automatic logic [W-1:0] next_stat(logic [W-1:0] s, logic [W-1:0] p,
                                               logic [W-1:0] h, logic r);
        return (r ? '0 : s) | p | (h & HOLD);
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic [W-1:0] p, logic [W-1:0] h, logic r,
                       logic w, logic [W-1:0] d, logic md);
        @(negedge clk);
        pulse = p; hold = h; rd = r; mwr = w; mdata = d; mode = md;
        m_stat = next_stat(m_stat, p, h, r);
        if (w) m_mask = d;
        m_pri = ~|(m_stat & m_mask);
        m_sec = md ? m_pri : 1'b1;
        @(posedge clk);
        #1;
        chk({tag, " stat"}, stat, m_stat);
        chk({tag, " pri"}, {31'd0, pri_n}, {31'd0, m_pri});
        chk({tag, " sec"}, {31'd0, sec_n}, {31'd0, m_sec});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset stat", stat, '0);
        chk("R1 reset irq", {30'd0, pri_n, sec_n}, 32'd3);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release", {stat[29:0], pri_n, sec_n}, 32'd3);

        cyc("R2 R5 pulse masked", 32'h20, '0, 0, 0, '0, 0);
        cyc("R10 hold set", '0, '0, 0, 0, '0, 0);
        @(negedge clk);
        chk("R3 read value pre-clear", stat, 32'h20);
        cyc("R3 read clear", '0, '0, 1, 0, '0, 0);
        cyc("R2 pulse bit3", 32'h8, '0, 0, 0, '0, 0);
        cyc("R4 set during read", 32'h80, '0, 1, 0, '0, 0);
        cyc("R7 mask write", '0, '0, 0, 1, 32'h80, 0);
        cyc("R8 mode low", '0, '0, 0, 0, '0, 0);
        cyc("R8 mode high", '0, '0, 0, 0, '0, 1);
        cyc("R7 mask off", '0, '0, 0, 1, 32'h0, 1);
        cyc("R9 hold on", '0, 32'h0100_0001, 0, 0, '0, 1);
        cyc("R9 hold through read", '0, 32'h0100_0001, 1, 0, '0, 1);
        cyc("R9 hold dropped", '0, '0, 1, 0, '0, 1);
        cyc("R9 hold ignored", '0, 32'h0000_00FF, 0, 0, '0, 0);
        cyc("R5 R6 set with mask", 32'h1, '0, 0, 1, 32'h1, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] p, h, d;
            p = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : '0;
            h = (($urandom % 6) == 0) ? $urandom : '0;
            d = $urandom & $urandom;
            cyc("R6 random", p, h, ($urandom % 5) == 0, ($urandom % 8) == 0, d,
                ($urandom % 2) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule